// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Read Sequencer

This block sits on the host side of a two-channel, simultaneous-sampling 12-bit converter and runs it without software help. While enabled, it repeats a fixed cycle. It chooses a channel pair on the address line and waits out the address setup time. It pulses the active-low convert strobe and then waits for the conversion to finish. A conversion is judged finished either when the converter's busy flag falls or when a fixed count of converter clocks has elapsed; a parameter selects which. The pair address alternates between 0 and 1 on every conversion.

The results of the previous conversion are fetched while the next conversion is already running. The sequencer drops chip-select, points the address at the finished pair, and issues two read pulses: the first returns channel A and the second returns channel B. The bus is sampled in the last system cycle of each pulse. Each sample is sign-extended and offered on a valid/ready stream, tagged with its pair and its channel.

Every timing minimum is a parameter in picoseconds and is turned into a whole number of system-clock cycles, rounded up. No read may fall inside the guard window around the strobe's falling edge. A downstream stall holds the read phase between pulses. Because all reads finish before the address for the next strobe is set, a stall can never push a read into the guard window.

Top module: `dual_adc_seq`

## Requirements
- R1: During and after a synchronous reset, `adc_cnv_n`, `adc_cs_n` and `adc_rd_n` are high, `m_valid` is low and `adc_addr` is 0. No strobe is issued until `run` is seen high.
- R2: `adc_addr` holds its value for at least ceil(T_SETUP_PS/SYS_PS) cycles (25 at the defaults) before `adc_cnv_n` falls. It stays unchanged while `adc_cnv_n` is low.
- R3: Each low pulse on `adc_cnv_n` lasts exactly ceil(T_CNV_PS/SYS_PS) cycles (1 at the defaults).
- R4: `adc_rd_n` is high at every strobe fall. It has been high for at least ceil(T_PRE_PS/SYS_PS) cycles (13) before the fall. It does not fall until at least ceil(T_POST_PS/SYS_PS) cycles (1) after the fall.
- R5: Each low pulse on `adc_rd_n` lasts exactly ceil(T_RD_PS/SYS_PS) cycles (3 at the defaults).
- R6: `adc_rd_n` is low only while `adc_cs_n` is low. Each chip-select window holds exactly two read pulses. The first yields a sample with `m_chan`=0 (channel A) and the second a sample with `m_chan`=1 (channel B).
- R7: `m_data` equals the 12-bit two's-complement bus value from the last low cycle of the read pulse, sign-extended to OW bits (bit 11 copied into bits 15..12 at the defaults).
- R8: The pair address starts at 0 and toggles on every conversion. `m_pair` equals the address value under which the sample's conversion was strobed. Samples leave in conversion order.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_pair` and `m_chan` hold. No read pulse begins while `m_valid` is high.
- R10: With USE_BUSY=1, no new strobe is issued until the busy flag of the previous conversion has been seen high and then low again.
- R11: The read of conversion k overlaps conversion k+1: `adc_rd_n` goes low while the converter reports busy.
- R12: When `run` drops, the sequencer finishes the conversion in flight and delivers both of its samples. It then returns to idle with every control line high. The number of strobes equals half the number of delivered samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep running conversion cycles while high |
| adc_addr | output | 1 | Channel-pair address to the converter |
| adc_cnv_n | output | 1 | Active-low convert strobe |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_rd_n | output | 1 | Active-low read enable |
| adc_busy | input | 1 | Converter busy flag (asynchronous, synchronised inside) |
| adc_data | input | DW | Converter parallel data bus, two's complement |
| m_valid | output | 1 | Sample stream valid |
| m_ready | input | 1 | Sample stream ready |
| m_data | output | OW | Sign-extended sample |
| m_pair | output | 1 | Pair address the sample belongs to |
| m_chan | output | 1 | 0 for channel A, 1 for channel B |

## Verification
Two events can coincide when the downstream side stalls. The end of a conversion (busy falling) can land while the read phase for the previous pair is still held back between or before its read pulses. The bench provokes this by holding `m_ready` low for 60 and 120 cycles per sample, which is longer than the 40-cycle conversion of its converter model. The sequencer must then wait until both reads are done, set up the new address and only then strobe. Correctness is judged in two ways. Every sample must still carry the right value and tags in order. Independent monitors must find no strobe inside the read guard window and no strobe while busy is high.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_POST,
    ST_REQA,
    ST_RDA,
    ST_GAP,
    ST_REQB,
    ST_RDB,
    ST_REND,
    ST_WAIT
  } seq_state_e;

  // Round a time in picoseconds up to whole system cycles, never below one.
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dadc_timer.sv
module dadc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/dadc_conv_wait.sv
module dadc_conv_wait #(
  parameter bit USE_BUSY = 1'b1,
  parameter int CONV_CYC = 68
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy_in,
  output logic done
);

  logic busy_m;
  logic busy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m <= 1'b0;
      busy_s <= 1'b0;
    end else begin
      busy_m <= busy_in;
      busy_s <= busy_m;
    end
  end

  generate
    if (USE_BUSY) begin : g_busy
      logic seen;
      always_ff @(posedge clk) begin
        if (rst) begin
          seen <= 1'b0;
        end else if (start) begin
          seen <= 1'b0;
        end else if (busy_s) begin
          seen <= 1'b1;
        end
      end
      assign done = seen && !busy_s;
    end else begin : g_count
      localparam int CW = $clog2(CONV_CYC + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (start) begin
          cnt <= CW'(CONV_CYC);
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end
      assign done = (cnt == '0) && !busy_s;
    end
  endgenerate

endmodule

// File: rtl/dadc_capture.sv
module dadc_capture #(
  parameter int DW = 12,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] bus,
  input  logic          cap_pair,
  input  logic          cap_chan,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [OW-1:0] m_data,
  output logic          m_pair,
  output logic          m_chan,
  output logic          slot_free
);

  logic [OW-1:0] ext;

  generate
    if (OW > DW) begin : g_sext
      assign ext = {{(OW - DW){bus[DW-1]}}, bus};
    end else begin : g_trim
      assign ext = bus[OW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_pair  <= 1'b0;
      m_chan  <= 1'b0;
    end else if (cap_en) begin
      m_valid <= 1'b1;
      m_data  <= ext;
      m_pair  <= cap_pair;
      m_chan  <= cap_chan;
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assign slot_free = !m_valid;

endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
  import dadc_pkg::*;
#(
  parameter int DW         = 12,
  parameter int OW         = 16,
  parameter int SYS_PS     = 10000,
  parameter int T_SETUP_PS = 250000,
  parameter int T_CNV_PS   = 5000,
  parameter int T_PRE_PS   = 125000,
  parameter int T_POST_PS  = 10000,
  parameter int T_RD_PS    = 30000,
  parameter int T_GAP_PS   = 10000,
  parameter bit USE_BUSY   = 1'b1,
  parameter int CONV_CLKS  = 16,
  parameter int CVT_DIV    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          adc_addr,
  output logic          adc_cnv_n,
  output logic          adc_cs_n,
  output logic          adc_rd_n,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_data,
  output logic          m_pair,
  output logic          m_chan
);

  localparam int SETUP_CYC = ps_to_cycles(T_SETUP_PS, SYS_PS);
  localparam int PRE_CYC   = ps_to_cycles(T_PRE_PS, SYS_PS);
  localparam int ADDR_CYC  = imax(SETUP_CYC, PRE_CYC);
  localparam int CNV_CYC   = ps_to_cycles(T_CNV_PS, SYS_PS);
  localparam int POST_CYC  = ps_to_cycles(T_POST_PS, SYS_PS);
  localparam int RD_CYC    = ps_to_cycles(T_RD_PS, SYS_PS);
  localparam int GAP_CYC   = ps_to_cycles(T_GAP_PS, SYS_PS);
  localparam int CONV_CYC  = (CONV_CLKS + 1) * CVT_DIV;
  localparam int MAXC      = imax(imax(ADDR_CYC, CNV_CYC),
                                  imax(imax(POST_CYC, RD_CYC), GAP_CYC));
  localparam int TW        = $clog2(MAXC + 1);

  seq_state_e    state, nxt;
  logic [TW-1:0] ld_val;
  logic          tmr_load, tmr_done;
  logic          conv_start, conv_done;
  logic          cap_en, cap_chan;
  logic          slot_free;
  logic          nxt_pair, cur_pair, done_pair;
  logic          has_prev, drain;

  dadc_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (ld_val),
    .done     (tmr_done)
  );

  dadc_conv_wait #(.USE_BUSY(USE_BUSY), .CONV_CYC(CONV_CYC)) u_conv (
    .clk     (clk),
    .rst     (rst),
    .start   (conv_start),
    .busy_in (adc_busy),
    .done    (conv_done)
  );

  dadc_capture #(.DW(DW), .OW(OW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .bus       (adc_data),
    .cap_pair  (adc_addr),
    .cap_chan  (cap_chan),
    .m_ready   (m_ready),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .m_pair    (m_pair),
    .m_chan    (m_chan),
    .slot_free (slot_free)
  );

  // Next-state decision.
  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (run) nxt = ST_ADDR;
      ST_ADDR: if (tmr_done) nxt = ST_STRB;
      ST_STRB: if (tmr_done) nxt = ST_POST;
      ST_POST: if (tmr_done) nxt = has_prev ? ST_REQA : ST_WAIT;
      ST_REQA: if (slot_free) nxt = ST_RDA;
      ST_RDA:  if (tmr_done) nxt = ST_GAP;
      ST_GAP:  if (tmr_done) nxt = ST_REQB;
      ST_REQB: if (slot_free) nxt = ST_RDB;
      ST_RDB:  if (tmr_done) nxt = ST_REND;
      ST_REND: nxt = drain ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (conv_done) nxt = run ? ST_ADDR : ST_REQA;
      default: nxt = ST_IDLE;
    endcase
  end

  // Dwell time loaded on entry to each timed state.
  always_comb begin
    unique case (nxt)
      ST_ADDR: ld_val = TW'(ADDR_CYC - 1);
      ST_STRB: ld_val = TW'(CNV_CYC - 1);
      ST_POST: ld_val = TW'(POST_CYC - 1);
      ST_RDA:  ld_val = TW'(RD_CYC - 1);
      ST_RDB:  ld_val = TW'(RD_CYC - 1);
      ST_GAP:  ld_val = TW'(GAP_CYC - 1);
      default: ld_val = '0;
    endcase
  end

  assign tmr_load   = (nxt != state);
  assign conv_start = (nxt == ST_STRB) && (state != ST_STRB);
  assign cap_en     = ((state == ST_RDA) || (state == ST_RDB)) && tmr_done;
  assign cap_chan   = (state == ST_RDB);

  function automatic logic in_read(input seq_state_e s);
    return (s == ST_REQA) || (s == ST_RDA) || (s == ST_GAP) ||
           (s == ST_REQB) || (s == ST_RDB);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      adc_cnv_n <= 1'b1;
      adc_cs_n  <= 1'b1;
      adc_rd_n  <= 1'b1;
      adc_addr  <= 1'b0;
      nxt_pair  <= 1'b0;
      cur_pair  <= 1'b0;
      done_pair <= 1'b0;
      has_prev  <= 1'b0;
      drain     <= 1'b0;
    end else begin
      state     <= nxt;
      adc_cnv_n <= (nxt != ST_STRB);
      adc_cs_n  <= !in_read(nxt);
      adc_rd_n  <= !((nxt == ST_RDA) || (nxt == ST_RDB));

      if ((nxt == ST_ADDR) && (state != ST_ADDR)) begin
        adc_addr <= nxt_pair;
      end else if ((nxt == ST_REQA) && (state != ST_REQA)) begin
        adc_addr <= (state == ST_WAIT) ? cur_pair : done_pair;
      end

      if (conv_start) begin
        cur_pair <= nxt_pair;
        nxt_pair <= !nxt_pair;
      end

      if ((state == ST_WAIT) && conv_done) begin
        done_pair <= cur_pair;
        has_prev  <= 1'b1;
        drain     <= !run;
      end else if ((state == ST_REND) && drain) begin
        has_prev <= 1'b0;
        drain    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dual_adc_seq_chk.sv
module dual_adc_seq_chk
  import dadc_pkg::*;
#(
  parameter int OW         = 16,
  parameter int SYS_PS     = 10000,
  parameter int T_SETUP_PS = 250000,
  parameter int T_CNV_PS   = 5000,
  parameter int T_PRE_PS   = 125000,
  parameter int T_POST_PS  = 10000,
  parameter int T_RD_PS    = 30000
) (
  input logic          clk,
  input logic          rst,
  input logic          adc_addr,
  input logic          adc_cnv_n,
  input logic          adc_cs_n,
  input logic          adc_rd_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [OW-1:0] m_data,
  input logic          m_pair,
  input logic          m_chan
);

  localparam int SETUP_CYC = ps_to_cycles(T_SETUP_PS, SYS_PS);
  localparam int PRE_CYC   = ps_to_cycles(T_PRE_PS, SYS_PS);
  localparam int CNV_CYC   = ps_to_cycles(T_CNV_PS, SYS_PS);
  localparam int POST_CYC  = ps_to_cycles(T_POST_PS, SYS_PS);
  localparam int RD_CYC    = ps_to_cycles(T_RD_PS, SYS_PS);

  logic [15:0] addr_age, rd_hi_age, cnv_age, rd_lo, cnv_lo;
  logic        addr_d, rd_d, cnv_d;

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_age  <= '0;
      rd_hi_age <= 16'hFFFF;
      cnv_age   <= '0;
      rd_lo     <= '0;
      cnv_lo    <= '0;
      addr_d    <= 1'b0;
      rd_d      <= 1'b1;
      cnv_d     <= 1'b1;
    end else begin
      addr_d    <= adc_addr;
      rd_d      <= adc_rd_n;
      cnv_d     <= adc_cnv_n;
      addr_age  <= (adc_addr != addr_d) ? 16'd1 : sat_inc(addr_age);
      rd_hi_age <= (adc_rd_n && !rd_d) ? 16'd1 : sat_inc(rd_hi_age);
      cnv_age   <= (!adc_cnv_n && cnv_d) ? 16'd1 : sat_inc(cnv_age);
      rd_lo     <= !adc_rd_n ? sat_inc(rd_lo) : 16'd0;
      cnv_lo    <= !adc_cnv_n ? sat_inc(cnv_lo) : 16'd0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (adc_cnv_n && adc_cs_n && adc_rd_n && !m_valid));

  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cnv_n) |-> (addr_age >= 16'(SETUP_CYC)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adc_cnv_n |-> $stable(adc_addr));

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cnv_n) |-> (cnv_lo == 16'(CNV_CYC)));

  // R4
  pre_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cnv_n) |-> (adc_rd_n && (rd_hi_age >= 16'(PRE_CYC))));

  // R4
  post_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rd_n) |-> (cnv_age >= 16'(POST_CYC)));

  // R5
  read_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rd_n) |-> (rd_lo == 16'(RD_CYC)));

  // R6
  read_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> !adc_cs_n);

  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=>
      (m_valid && $stable(m_data) && $stable(m_pair) && $stable(m_chan)));

  // R9
  no_read_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rd_n) |-> !m_valid);

endmodule

bind dual_adc_seq dual_adc_seq_chk #(
  .OW(OW), .SYS_PS(SYS_PS), .T_SETUP_PS(T_SETUP_PS), .T_CNV_PS(T_CNV_PS),
  .T_PRE_PS(T_PRE_PS), .T_POST_PS(T_POST_PS), .T_RD_PS(T_RD_PS)
) u_chk (
  .clk(clk), .rst(rst), .adc_addr(adc_addr), .adc_cnv_n(adc_cnv_n),
  .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_pair(m_pair), .m_chan(m_chan)
);

// File: tb/dual_adc_seq_test.sv
module dual_adc_seq_test;

  localparam int CONV_T  = 40;
  localparam int SETUP_C = 25;
  localparam int PRE_C   = 13;
  localparam int POST_C  = 1;
  localparam int RD_C    = 3;
  localparam int CNV_C   = 1;
  localparam int NVEC    = 6;
  // per row: samples to take, ready stall cycles per sample
  localparam int VEC [NVEC][2] = '{'{4, 0}, '{4, 3}, '{2, 60}, '{6, 1}, '{2, 120}, '{4, 0}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        m_ready = 1'b0;
  logic        adc_addr, adc_cnv_n, adc_cs_n, adc_rd_n;
  logic        adc_busy;
  logic [11:0] adc_data;
  logic        m_valid, m_pair, m_chan;
  logic [15:0] m_data;

  int checks = 0;
  int fails  = 0;
  int sidx   = 0;
  bit neg_seen = 0;
  bit pos_seen = 0;

  always #5 clk = ~clk;

  dual_adc_seq uut (
    .clk(clk), .rst(rst), .run(run), .adc_addr(adc_addr), .adc_cnv_n(adc_cnv_n),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_busy(adc_busy), .adc_data(adc_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_pair(m_pair), .m_chan(m_chan)
  );

  function automatic logic [11:0] code(input int k, input int ch);
    return 12'((k * 419 + ch * 1637 + ((k % 3 == 0) ? 2048 : 0)) & 12'hFFF);
  endfunction

  // ---------------- converter model ----------------
  logic [11:0] res_a [2];
  logic [11:0] res_b [2];
  int   conv_k, lat_k, bcnt;
  logic lat_pair, cnv_q, rd_q, bsel;

  always @(posedge clk) begin
    if (rst) begin
      adc_busy <= 1'b0; conv_k <= 0; lat_k <= 0; bcnt <= 0; lat_pair <= 1'b0;
      cnv_q <= 1'b1; rd_q <= 1'b1; bsel <= 1'b0;
      res_a[0] <= '0; res_a[1] <= '0; res_b[0] <= '0; res_b[1] <= '0;
    end else begin
      cnv_q <= adc_cnv_n;
      rd_q  <= adc_rd_n;
      if (cnv_q && !adc_cnv_n) begin
        adc_busy <= 1'b1; bcnt <= CONV_T; lat_k <= conv_k;
        lat_pair <= adc_addr; conv_k <= conv_k + 1;
      end else if (adc_busy) begin
        if (bcnt == 1) begin
          adc_busy <= 1'b0;
          res_a[lat_pair] <= code(lat_k, 0);
          res_b[lat_pair] <= code(lat_k, 1);
        end
        bcnt <= bcnt - 1;
      end
      if (adc_cs_n) bsel <= 1'b0;
      else if (!rd_q && adc_rd_n) bsel <= 1'b1;
    end
  end

  assign adc_data = (!adc_cs_n && !adc_rd_n) ? (bsel ? res_b[adc_addr] : res_a[adc_addr]) : 12'hA5A;

  // ---------------- timing monitors ----------------
  int age_addr, hi_rd, since_cnv, lo_rd, lo_cnv, strobes;
  int v_r2, v_r3, v_r4, v_r5, v_r6, v_r9, v_r10;
  bit overlap_seen;
  logic m_addr_q, m_cnv_q, m_rd_q;

  always @(posedge clk) begin
    if (rst) begin
      age_addr = 0; hi_rd = 1000; since_cnv = 0; lo_rd = 0; lo_cnv = 0; strobes = 0;
      m_addr_q = 1'b0; m_cnv_q = 1'b1; m_rd_q = 1'b1;
    end else begin
      if (m_cnv_q && !adc_cnv_n) begin
        strobes++;
        if (age_addr < SETUP_C) v_r2++;
        if (!adc_rd_n || hi_rd < PRE_C) v_r4++;
        if (adc_busy) v_r10++;
      end
      if (!adc_cnv_n && adc_addr != m_addr_q) v_r2++;
      if (m_rd_q && !adc_rd_n) begin
        if (since_cnv < POST_C) v_r4++;
        if (m_valid) v_r9++;
      end
      if (!m_rd_q && adc_rd_n && lo_rd != RD_C) v_r5++;
      if (!m_cnv_q && adc_cnv_n && lo_cnv != CNV_C) v_r3++;
      if (!adc_rd_n && adc_cs_n) v_r6++;
      if (!adc_rd_n && adc_busy) overlap_seen = 1;
      age_addr  = (adc_addr != m_addr_q) ? 1 : age_addr + 1;
      hi_rd     = (adc_rd_n && !m_rd_q) ? 1 : hi_rd + 1;
      since_cnv = (!adc_cnv_n && m_cnv_q) ? 1 : since_cnv + 1;
      lo_rd     = !adc_rd_n ? lo_rd + 1 : 0;
      lo_cnv    = !adc_cnv_n ? lo_cnv + 1 : 0;
      m_addr_q = adc_addr; m_cnv_q = adc_cnv_n; m_rd_q = adc_rd_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Take one sample with a given stall; returns got=0 if none arrives in time.
  task automatic take(input int stall, input int wait_lim, output bit got);
    logic [15:0] first;
    logic [11:0] c;
    logic [15:0] exp_d;
    int k, ch;
    got = 0;
    for (int w = 0; w < wait_lim && !m_valid; w++) @(negedge clk);
    if (!m_valid) return;
    got = 1;
    first = m_data;
    for (int s = 0; s < stall; s++) @(negedge clk);
    if (stall > 0)
      check(m_valid && m_data == first, "R9", "held sample under stall", m_data, first);
    k = sidx / 2; ch = sidx % 2;
    c = code(k, ch);
    exp_d = {{4{c[11]}}, c};
    if (c[11]) neg_seen = 1; else pos_seen = 1;
    check(m_data == exp_d, "R7", "sign-extended data", m_data, exp_d);
    check(m_pair == 1'(k % 2) && m_chan == 1'(ch), "R6/R8 tags",
          "pair,chan", {m_pair, m_chan}, {1'(k % 2), 1'(ch)});
    sidx++;
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit got;
    v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r9 = 0; v_r10 = 0;
    overlap_seen = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1: idle after reset with run low
    check(adc_cnv_n && adc_cs_n && adc_rd_n && !m_valid && !adc_addr,
          "R1", "idle controls", {adc_cnv_n, adc_cs_n, adc_rd_n, m_valid, adc_addr}, 5'b11100);
    run = 1'b1;

    for (int r = 0; r < NVEC; r++) begin
      for (int n = 0; n < VEC[r][0]; n++) begin
        take(VEC[r][1], 2000, got);
        check(got, "R8", "sample arrived", got, 1);
      end
    end

    check(v_r2 == 0, "R2", "address setup/hold violations", v_r2, 0);
    check(v_r3 == 0, "R3", "strobe width violations", v_r3, 0);
    check(v_r4 == 0, "R4", "read guard violations", v_r4, 0);
    check(v_r5 == 0, "R5", "read width violations", v_r5, 0);
    check(v_r6 == 0, "R6", "read outside select", v_r6, 0);
    check(v_r9 == 0, "R9", "read started with full slot", v_r9, 0);
    check(v_r10 == 0, "R10", "strobe while busy", v_r10, 0);
    check(overlap_seen, "R11", "read overlapped conversion", overlap_seen, 1);
    check(neg_seen && pos_seen, "R7", "both signs seen", {neg_seen, pos_seen}, 2'b11);

    // R12: drop run and drain
    run = 1'b0;
    got = 1;
    while (got) take(0, 400, got);
    repeat (200) @(negedge clk);
    check(strobes * 2 == sidx, "R12", "strobes vs samples", strobes * 2, sidx);
    check(adc_cnv_n && adc_cs_n && adc_rd_n && !m_valid, "R12", "idle after drain",
          {adc_cnv_n, adc_cs_n, adc_rd_n, m_valid}, 4'b1110);
    check(sidx % 2 == 0, "R6", "samples come in A/B pairs", sidx % 2, 0);

    summary();
    $finish;
  end

endmodule